// File: doc/BRIEF.md
# Serial EEPROM Write Controller

This block is the control core of a two-wire serial memory slave holding a 256-byte array. A bit-level front end, not part of this block, decodes the bus. It passes in start and stop events, address-byte events that say whether the slave address matched and whether the access is a read, and received data bytes. The block keeps the word address pointer and returns an acknowledge or not-acknowledge decision for every byte. It streams read data out and gathers write data into a 16-byte page buffer.

A write sequence has two parts. The first data byte after a write address sets the word address. Each later byte goes into the page buffer at the low four address bits, and only those four bits advance, wrapping inside the page. The buffer is written to the array only when a stop ends the sequence. That commit starts a busy window of a parameterised number of clock cycles. During the window the block refuses its slave address and ignores all other bus traffic. A high write-protect input or a low-supply flag blocks the commit. Data bytes are still acknowledged in that case.

Data flows on two valid/ready streams. A received byte is taken when `wr_valid` and `wr_ready` are both high; `wr_ready` is low only during the busy window. A read byte is offered with `rd_valid`, and the pointer advances only when the consumer raises `rd_ready` in the same cycle. `rd_data` stays stable while the consumer holds `rd_ready` low.

Top module: `eeprom_wctl`

## Requirements
- R1: After reset `busy`, `ack_valid` and `rd_valid` are 0, `wr_ready` is 1, and every array byte reads 8'hFF.
- R2: One cycle after an address event, `ack_valid` is 1 and `ack` equals `addr_hit`, provided the block is not busy. A hit with `addr_rd`=1 enters read mode, a hit with `addr_rd`=0 enters write mode, and a miss returns to idle.
- R3: In read mode, `rd_data` is the byte at the word address. Each accepted read byte (`rd_valid`&&`rd_ready`) advances the address by one, wrapping from 255 to 0.
- R4: The first accepted data byte in write mode sets the word address. Each later byte is stored at the current address. Only address bits [3:0] then advance, wrapping 15 to 0, so that a 17th or later byte overwrites earlier ones. Each of these bytes is acknowledged.
- R5: A stop after at least one stored page byte writes the page to the array. `busy` then rises on the stop's clock edge and stays high for exactly BUSY_CYCLES cycles.
- R6: While `busy` is 1, address events get a not-acknowledge, `wr_ready` and `rd_valid` are 0, and start and stop events have no effect.
- R7: If `wp` is 1 at any page byte or at the stop, the page bytes are still acknowledged, but nothing is written and `busy` stays 0.
- R8: If `vlow` is 1 at any page byte or at the stop, the page bytes are still acknowledged, but nothing is written and `busy` stays 0.
- R9: A stop that arrives before any page byte writes nothing and starts no busy window. A start that arrives after page bytes discards them: nothing is written and `busy` stays 0.
- R10: A data byte accepted in idle or read mode gets `ack_valid`=1, `ack`=0. `ack_valid` pulses only in the cycle after an address event or an accepted data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp | input | 1 | Write protect, 1 blocks writes |
| vlow | input | 1 | Supply-low flag, 1 blocks writes |
| bus_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen (one-cycle pulse) |
| addr_valid | input | 1 | An address byte was received |
| addr_hit | input | 1 | The address byte matched this slave |
| addr_rd | input | 1 | Direction bit of the address byte, 1 = read |
| wr_valid | input | 1 | Received data byte valid |
| wr_data | input | 8 | Received data byte |
| wr_ready | output | 1 | Block can take a data byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| ack_valid | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bench first reads the whole array from its reset state. It then rewrites all sixteen pages, each starting at a different in-page offset, and compares every byte against a model computed in the bench. This separates a correct in-page wrap from a carry into the upper address bits or a fixed start offset. Page loads made under write protect and under low supply are compared against the full expected array. Each such load carries a distinctive pattern, so any leaked byte shows up. Further sequences separate commit at the stop from commit on other events: an overlong load, an aborted load, an empty write, traffic during busy, and a stalled read handshake.

// File: rtl/eew_pkg.sv
package eew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WADDR = 2'd1,
    ST_WDATA = 2'd2,
    ST_READ  = 2'd3
  } eew_state_e;
endpackage

// File: rtl/eew_regfile.sv
module eew_regfile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eew_pagebuf.sv
module eew_pagebuf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [PAGE_W-1:0] lidx,
  input  logic [DATA_W-1:0] ldata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              any
);
  localparam int PAGE = 1 << PAGE_W;

  logic [DATA_W-1:0] slot  [PAGE];
  logic [PAGE-1:0]   vbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbits <= '0;
      for (int i = 0; i < PAGE; i++) slot[i] <= '0;
    end else if (clr) begin
      vbits <= '0;
    end else if (load) begin
      slot[lidx]  <= ldata;
      vbits[lidx] <= 1'b1;
    end
  end

  assign rdata  = slot[ridx];
  assign rvalid = vbits[ridx];
  assign any    = |vbits;
endmodule

// File: rtl/eew_busy.sv
module eew_busy #(
  parameter int BUSY_CYCLES = 24,
  parameter int PAGE_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  output logic              busy,
  output logic              cmt_en,
  output logic [PAGE_W-1:0] cmt_idx
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [PAGE_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmt_en  <= 1'b0;
      cmt_idx <= '0;
    end else if (kick) begin
      cnt     <= CNT_W'(BUSY_CYCLES);
      cmt_en  <= 1'b1;
      cmt_idx <= '0;
    end else begin
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      if (cmt_en) begin
        cmt_idx <= cmt_idx + PAGE_W'(1);
        if (cmt_idx == LAST) cmt_en <= 1'b0;
      end
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/eeprom_wctl.sv
module eeprom_wctl
  import eew_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic              vlow,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_valid,
  input  logic              addr_hit,
  input  logic              addr_rd,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_valid,
  output logic              ack,
  output logic              busy
);
  localparam int HI_W = ADDR_W - PAGE_W;

  eew_state_e        st;
  logic [ADDR_W-1:0] addr_q;
  logic              blk_q;

  logic              cmt_en;
  logic [PAGE_W-1:0] cmt_idx;
  logic [DATA_W-1:0] pb_rdata;
  logic              pb_rvalid, pb_any;

  logic data_slot, wr_take, rd_take, kick, pb_clr, pb_load;

  assign wr_ready  = !busy;
  assign rd_valid  = (st == ST_READ) && !busy;
  assign wr_take   = wr_valid && wr_ready;
  assign rd_take   = rd_valid && rd_ready;
  assign data_slot = !busy && !bus_start && !bus_stop && !addr_valid;
  assign pb_clr    = data_slot && wr_take && (st == ST_WADDR);
  assign pb_load   = data_slot && wr_take && (st == ST_WDATA);
  assign kick      = !busy && bus_stop && !bus_start && (st == ST_WDATA)
                     && pb_any && !blk_q && !wp && !vlow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      blk_q     <= 1'b0;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
    end else begin
      ack_valid <= 1'b0;
      if (busy) begin
        if (addr_valid) begin
          ack_valid <= 1'b1;
          ack       <= 1'b0;
        end
      end else if (bus_start || bus_stop) begin
        st <= ST_IDLE;
      end else if (addr_valid) begin
        ack_valid <= 1'b1;
        ack       <= addr_hit;
        if (!addr_hit)    st <= ST_IDLE;
        else if (addr_rd) st <= ST_READ;
        else              st <= ST_WADDR;
      end else begin
        if (wr_take) begin
          ack_valid <= 1'b1;
          case (st)
            ST_WADDR: begin
              addr_q <= wr_data[ADDR_W-1:0];
              blk_q  <= 1'b0;
              ack    <= 1'b1;
              st     <= ST_WDATA;
            end
            ST_WDATA: begin
              addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
              blk_q  <= blk_q | wp | vlow;
              ack    <= 1'b1;
            end
            default: ack <= 1'b0;
          endcase
        end
        if (rd_take) addr_q <= addr_q + ADDR_W'(1);
      end
    end
  end

  eew_busy #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .kick(kick),
    .busy(busy), .cmt_en(cmt_en), .cmt_idx(cmt_idx)
  );

  eew_pagebuf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .load(pb_load),
    .lidx(addr_q[PAGE_W-1:0]), .ldata(wr_data),
    .ridx(cmt_idx), .rdata(pb_rdata), .rvalid(pb_rvalid), .any(pb_any)
  );

  logic [HI_W-1:0] page_hi;
  assign page_hi = addr_q[ADDR_W-1:PAGE_W];

  eew_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we(cmt_en && pb_rvalid), .waddr({page_hi, cmt_idx}), .wdata(pb_rdata),
    .raddr(addr_q), .rdata(rd_data)
  );
endmodule

module eeprom_wctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp,
  input logic              vlow,
  input logic              bus_stop,
  input logic              addr_valid,
  input logic              addr_hit,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              ack_valid,
  input logic              ack,
  input logic              busy
);
  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && addr_valid |=> ack_valid && !ack);
  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready && !rd_valid);
  // R2
  miss_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_hit |=> ack_valid && !ack);
  // R10
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(addr_valid || (wr_valid && wr_ready)));
  // R5
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));
  // R7
  busy_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));
  // R8
  busy_vlow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(vlow));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> $stable(rd_data));
endmodule

bind eeprom_wctl eeprom_wctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp(wp), .vlow(vlow), .bus_stop(bus_stop),
  .addr_valid(addr_valid), .addr_hit(addr_hit), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .ack_valid(ack_valid), .ack(ack), .busy(busy)
);

// File: tb/eeprom_wctl_tb.sv
module eeprom_wctl_tb;
  localparam int BUSY = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, vlow = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
  logic addr_valid = 1'b0, addr_hit = 1'b0, addr_rd = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, rd_valid, ack_valid, ack, busy;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_mem [256];

  always #10 clk = ~clk;

  eeprom_wctl #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp(wp), .vlow(vlow), .bus_start(bus_start),
    .bus_stop(bus_stop), .addr_valid(addr_valid), .addr_hit(addr_hit),
    .addr_rd(addr_rd), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .ack_valid(ack_valid), .ack(ack), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send_addr(input bit hit, input bit rd, output bit av, output bit ak);
    addr_valid = 1'b1; addr_hit = hit; addr_rd = rd;
    @(posedge clk); #1; av = ack_valid; ak = ack;
    @(negedge clk); addr_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output bit av, output bit ak);
    wr_valid = 1'b1; wr_data = d;
    @(posedge clk); #1; av = ack_valid; ak = ack;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] d, output bit v);
    v = rd_valid; d = rd_data; rd_ready = 1'b1;
    @(posedge clk); @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic pulse_start();
    bus_start = 1'b1; @(posedge clk); @(negedge clk); bus_start = 1'b0;
  endtask

  // returns number of cycles busy was high after the stop
  task automatic stop_measure(output int n);
    bus_stop = 1'b1;
    @(posedge clk); #1; n = busy ? 1 : 0;
    @(negedge clk); bus_stop = 1'b0;
    if (n != 0) begin
      while (1) begin
        @(posedge clk); #1;
        if (busy) n++; else break;
      end
      @(negedge clk);
    end
  endtask

  task automatic set_pointer(input int a);
    bit av, ak;
    pulse_start();
    send_addr(1'b1, 1'b0, av, ak); chk(av && ak, "R2 write addr ack", ak, 1);
    send_byte(8'(a), av, ak);      chk(av && ak, "R4 word addr ack", ak, 1);
    pulse_start();
    send_addr(1'b1, 1'b1, av, ak); chk(av && ak, "R2 read addr ack", ak, 1);
  endtask

  task automatic read_all(input int start, input string req);
    logic [7:0] d; bit v; int n;
    set_pointer(start);
    for (int i = 0; i < 257; i++) begin
      read_byte(d, v);
      chk(v && d == exp_mem[(start + i) % 256], req, int'(d), int'(exp_mem[(start + i) % 256]));
    end
    stop_measure(n); chk(n == 0, "R9 stop in read no busy", n, 0);
  endtask

  function automatic logic [7:0] pat(input int a, input int seed, input int i);
    return 8'((a * 37 + seed * 11 + i * 5) & 255);
  endfunction

  task automatic write_page(input int a, input int cnt, input int seed,
                            input bit wpv, input bit vlv, input string req);
    bit av, ak; int n, idx; logic [7:0] d;
    wp = wpv; vlow = vlv;
    pulse_start();
    send_addr(1'b1, 1'b0, av, ak); chk(av && ak, "R2 write addr ack", ak, 1);
    send_byte(8'(a), av, ak);      chk(av && ak, "R4 word addr ack", ak, 1);
    for (int i = 0; i < cnt; i++) begin
      d = pat(a, seed, i);
      send_byte(d, av, ak); chk(av && ak, req, ak, 1);
      idx = (a & 8'hF0) | ((a + i) & 4'hF);
      if (!wpv && !vlv) exp_mem[idx] = d;
    end
    stop_measure(n);
    chk(n == ((wpv || vlv) ? 0 : BUSY), req, n, (wpv || vlv) ? 0 : BUSY);
    wp = 1'b0; vlow = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (R1..): actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit av, ak; int n; logic [7:0] d, d0; bit v;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!busy, "R1 busy", busy, 0);
    chk(!ack_valid, "R1 ack_valid", ack_valid, 0);
    chk(!rd_valid, "R1 rd_valid", rd_valid, 0);
    chk(wr_ready, "R1 wr_ready", wr_ready, 1);
    @(negedge clk);
    // R10 data byte while idle is refused
    send_byte(8'h55, av, ak); chk(av && !ak, "R10 idle data nack", ak, 0);
    // R2 address miss
    pulse_start();
    send_addr(1'b0, 1'b0, av, ak); chk(av && !ak, "R2 miss nack", ak, 0);
    // R1/R3 full reset contents, with wrap
    read_all(0, "R1 R3 reset read");
    // R4/R5 every page, varying start offset
    for (int p = 0; p < 16; p++) write_page(p * 16 + p, 16, p, 1'b0, 1'b0, "R4 R5 page write");
    read_all(5, "R3 R4 readback");
    // R7 write protect
    write_page(8'h30, 16, 77, 1'b1, 1'b0, "R7 wp page");
    // R8 low supply
    write_page(8'h5A, 9, 91, 1'b0, 1'b1, "R8 vlow page");
    read_all(250, "R7 R8 unchanged");
    // R4 overlong load wraps and overwrites
    write_page(8'h72, 20, 33, 1'b0, 1'b0, "R4 overlong");
    // R9 start aborts loaded bytes
    pulse_start();
    send_addr(1'b1, 1'b0, av, ak);
    send_byte(8'hA4, av, ak);
    for (int i = 0; i < 3; i++) send_byte(8'(8'hC0 + i), av, ak);
    pulse_start();
    stop_measure(n); chk(n == 0, "R9 abort no busy", n, 0);
    // R9 stop right after word address
    pulse_start();
    send_addr(1'b1, 1'b0, av, ak);
    send_byte(8'hB0, av, ak);
    stop_measure(n); chk(n == 0, "R9 empty write no busy", n, 0);
    // R6 traffic during busy
    pulse_start();
    send_addr(1'b1, 1'b0, av, ak);
    send_byte(8'h9E, av, ak);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'(8'h10 + i), av, ak);
      exp_mem[8'h90 | ((8'hE + i) & 4'hF)] = 8'(8'h10 + i);
    end
    bus_stop = 1'b1; @(posedge clk); @(negedge clk); bus_stop = 1'b0;
    chk(busy, "R5 busy after stop", busy, 1);
    send_addr(1'b1, 1'b0, av, ak); chk(av && !ak, "R6 busy addr nack", ak, 0);
    chk(!wr_ready, "R6 wr_ready low", wr_ready, 0);
    chk(!rd_valid, "R6 rd_valid low", rd_valid, 0);
    pulse_start();
    bus_stop = 1'b1; @(posedge clk); @(negedge clk); bus_stop = 1'b0;
    while (busy) @(negedge clk);
    read_all(0, "R4 R6 R9 final readback");
    // R3 read handshake stall, R10 data in read mode
    set_pointer(8'h40);
    d0 = rd_data;
    chk(rd_valid && d0 == exp_mem[8'h40], "R3 offered byte", int'(d0), int'(exp_mem[8'h40]));
    repeat (3) @(negedge clk);
    chk(rd_data == d0, "R3 stall holds", int'(rd_data), int'(d0));
    send_byte(8'h77, av, ak); chk(av && !ak, "R10 read-mode data nack", ak, 0);
    read_byte(d, v); chk(v && d == exp_mem[8'h40], "R3 first read", int'(d), int'(exp_mem[8'h40]));
    read_byte(d, v); chk(v && d == exp_mem[8'h41], "R3 next read", int'(d), int'(exp_mem[8'h41]));
    stop_measure(n);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule